// File: doc/BRIEF.md
# System Bus Address Decoder with Boot ROM Overlay

This block sits between a 24-bit CPU bus and the memories and registers behind it. It sorts every access into one of five regions: boot ROM, main RAM, video RAM, page-map RAM, or the I/O space. For the selected region it produces a chip select and a local byte offset, masked to that region's size. It moves write data and read data between the bus and the memory lanes in big-endian order. Reads from the I/O space return all ones at the width of the access.

After reset a boot overlay is in force. Address bit 23 is forced high before decoding, so the CPU fetches its reset vectors and first code from ROM whatever address it issues. Software ends the overlay by setting a control bit through a write to a fixed I/O address. The block also holds a four-bit active-low LED register that is loaded by a word write to another fixed I/O address.

Top module: `sysbus_decoder`

## Requirements
- R1: After synchronous reset the overlay release flag `ram_low_en` is 0 and `led_n` is 4'b1111 (all LEDs off).
- R2: While `ram_low_en` is 0, address bit 23 is forced to 1 before decoding. An access to 0x000004 therefore selects ROM at local offset 0x0004, and 0x4A0000 decodes as the I/O address 0xCA0000.
- R3: Effective addresses 0x800000..0xBFFFFF select ROM, and `mem_addr` is the address ANDed with ROM_BYTES-1 (0x7FFF by default).
- R4: Effective addresses below RAM_BYTES (0x80000 by default) select main RAM, with `mem_addr` equal to the address. 0x7FFFF is RAM and 0x80000 is not.
- R5: 0x420000..0x427FFF selects video RAM with `mem_addr` = address & 0x7FFF. The addresses 0x41FFFF and 0x428000 are I/O.
- R6: 0x400000..0x4007FF selects map RAM with `mem_addr` = address & 0x7FF. The address 0x400800 is I/O.
- R7: Priority is ROM, RAM, video RAM, map RAM, then I/O. An I/O access gives `mem_addr` equal to the effective address. Exactly one select is high while `bus_valid` is 1, no select is high while it is 0, and `mem_we` is high only for writes to RAM, video RAM or map RAM.
- R8: A read of the I/O space returns ones at the access width: 0x000000FF for a byte, 0x0000FFFF for a word, 0xFFFFFFFF for a long. Bits above the access width are 0.
- R9: A write to ROM space is ignored. `mem_we` stays 0, and neither `ram_low_en` nor `led_n` changes.
- R10: A write to effective address 0xE43000 loads `ram_low_en` on the next clock. The value comes from `bus_wdata[7]` for a byte write (`bus_size` 2'b00), or from `bus_wdata[15]` for a word (2'b01) or long (2'b10 or 2'b11) write.
- R11: A word write to effective address 0xE43000's neighbour register at 0x4A0000 loads `led_n` from `bus_wdata[11:8]` on the next clock, where a 0 bit lights an LED. Byte and long writes there leave `led_n` unchanged.
- R12: Memory lanes are big-endian. Lane 0 is `mem_lanes[3]` on data bits 31:24 and holds the lowest address. A byte access enables lanes 4'b1000, a word 4'b1100 and a long 4'b1111. Write data is left-justified onto `mem_wdata` (0x000000CC as a byte gives 0xCC000000). Memory read data is right-justified onto `bus_rdata` (0xDEADBEEF as a byte gives 0x000000DE, as a word 0x0000DEAD).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 word, 10/11 long |
| bus_addr | input | 24 | CPU byte address |
| bus_wdata | input | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data from the selected array, lane 0 in bits 31:24 |
| bus_rdata | output | 32 | Read data to the CPU, right-justified |
| sel_rom | output | 1 | Boot ROM select |
| sel_ram | output | 1 | Main RAM select |
| sel_vram | output | 1 | Video RAM select |
| sel_map | output | 1 | Page-map RAM select |
| sel_io | output | 1 | I/O space select |
| mem_addr | output | 24 | Local offset of the first byte (I/O: full effective address) |
| mem_we | output | 1 | Write strobe to a writable array |
| mem_wdata | output | 32 | Write data, left-justified, lane 0 in bits 31:24 |
| mem_lanes | output | 4 | Lane enables, bit 3 = lane 0 |
| ram_low_en | output | 1 | Overlay released (0 = all accesses forced into ROM) |
| led_n | output | 4 | Active-low LED drive |

## Verification
The assertions watch several properties on every cycle. Exactly one region is selected per access, and the overlay only ever yields ROM or I/O. Local offsets stay inside their region, and lane enables have a legal shape. I/O reads carry ones at the access width, ROM writes leave both registers untouched, and the overlay and LED registers follow the write data bits they are defined to take. Some behaviour only the bench's scenarios can show: the exact region boundaries and their priority, the numeric local offsets, and the big-endian byte placement of particular data values. The bench also shows the interaction between the overlay and the LED address, where a word write to 0x4A0000 is lost while the overlay holds.

// File: rtl/sysdec_pkg.sv
// Package: shared types and helpers for the system bus decoder.
// Assumes a 32-bit data path with four byte lanes and a two-bit size code.
package sysdec_pkg;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROM,
        RG_RAM,
        RG_VRAM,
        RG_MAP,
        RG_IO
    } region_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic vram;
        logic map;
        logic io;
    } sel_t;

    // Number of bytes moved by an access of the given size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // All-ones pattern at the width of an access, right-justified.
    function automatic logic [31:0] ones_for(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sysdec_region.sv
// Module: sysdec_region
// Applies the boot overlay (forces one address bit high while the overlay
// holds), then classifies the effective address into one region with fixed
// priority ROM > RAM > VRAM > MAP > IO and masks it to a local offset.
// Assumes every region size is a power of two and that RAM_BYTES fits in
// ADDR_W bits. Purely combinational; clk/rst_n serve the assertions.
module sysdec_region
    import sysdec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int FORCE_BIT  = 23,
    parameter int ROM_BASE   = 'h80_0000,
    parameter int ROM_SPAN   = 'h40_0000,
    parameter int ROM_BYTES  = 'h8000,
    parameter int RAM_BYTES  = 'h8_0000,
    parameter int VRAM_BASE  = 'h42_0000,
    parameter int VRAM_BYTES = 'h8000,
    parameter int MAP_BASE   = 'h40_0000,
    parameter int MAP_BYTES  = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              low_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] local_addr,
    output sel_t              sel
);

    localparam logic [ADDR_W-1:0] ROM_LO    = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] ROM_HI    = ADDR_W'(ROM_BASE + ROM_SPAN - 1);
    localparam logic [ADDR_W-1:0] ROM_MASK  = ADDR_W'(ROM_BYTES - 1);
    localparam logic [ADDR_W-1:0] RAM_TOP   = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] RAM_MASK  = ADDR_W'(RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] VRAM_LO   = ADDR_W'(VRAM_BASE);
    localparam logic [ADDR_W-1:0] VRAM_HI   = ADDR_W'(VRAM_BASE + VRAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] VRAM_MASK = ADDR_W'(VRAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] MAP_LO    = ADDR_W'(MAP_BASE);
    localparam logic [ADDR_W-1:0] MAP_HI    = ADDR_W'(MAP_BASE + MAP_BYTES - 1);
    localparam logic [ADDR_W-1:0] MAP_MASK  = ADDR_W'(MAP_BYTES - 1);

    logic    hit_rom, hit_ram, hit_vram, hit_map;
    region_e region;

    // Force the overlay bit while the overlay has not been released.
    always_comb begin : force_p
        eff_addr = addr;
        if (!low_en) begin
            eff_addr[FORCE_BIT] = 1'b1;
        end
    end

    // Raw range hits on the effective address.
    always_comb begin : hit_p
        hit_rom  = (eff_addr >= ROM_LO)  && (eff_addr <= ROM_HI);
        hit_ram  = (eff_addr <  RAM_TOP);
        hit_vram = (eff_addr >= VRAM_LO) && (eff_addr <= VRAM_HI);
        hit_map  = (eff_addr >= MAP_LO)  && (eff_addr <= MAP_HI);
    end

    // Priority pick of the region and its masked local offset.
    always_comb begin : prio_p
        region     = RG_NONE;
        local_addr = '0;
        if (valid) begin
            if (hit_rom) begin
                region     = RG_ROM;
                local_addr = eff_addr & ROM_MASK;
            end else if (hit_ram) begin
                region     = RG_RAM;
                local_addr = eff_addr & RAM_MASK;
            end else if (hit_vram) begin
                region     = RG_VRAM;
                local_addr = eff_addr & VRAM_MASK;
            end else if (hit_map) begin
                region     = RG_MAP;
                local_addr = eff_addr & MAP_MASK;
            end else begin
                region     = RG_IO;
                local_addr = eff_addr;
            end
        end
    end

    // Expand the region code into individual selects.
    always_comb begin : sel_p
        sel.rom  = (region == RG_ROM);
        sel.ram  = (region == RG_RAM);
        sel.vram = (region == RG_VRAM);
        sel.map  = (region == RG_MAP);
        sel.io   = (region == RG_IO);
    end

    // R7
    sel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones(sel) == 1));
    // R7
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (sel == '0));
    // R2
    ovl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !low_en) |-> (sel.rom || sel.io));
    // R3
    rom_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.rom |-> (local_addr <= ROM_MASK));
    // R5
    vram_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.vram |-> (local_addr <= VRAM_MASK));
    // R6
    map_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.map |-> (local_addr <= MAP_MASK));

endmodule

// File: rtl/sysdec_lanes.sv
// Module: sysdec_lanes
// Big-endian byte-lane steering. Lane 0 (bits 31:24, enable bit 3) holds the
// lowest address. Write data arrives right-justified and leaves left-justified;
// memory read data is right-justified back to the bus, and I/O reads return
// ones at the access width. Assumes four lanes and the package size codes.
module sysdec_lanes
    import sysdec_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               write,
    input  logic [1:0]         size,
    input  logic               mem_sel,
    input  logic               io_sel,
    input  logic [8*LANES-1:0] wdata,
    input  logic [8*LANES-1:0] mem_rdata,
    output logic [LANES-1:0]   lanes,
    output logic [8*LANES-1:0] mem_wdata,
    output logic [8*LANES-1:0] bus_rdata
);

    localparam int LAST = LANES - 1;

    logic [2:0] nb;

    assign nb = size_bytes(size);

    for (genvar k = 0; k < LANES; k++) begin : g_wr
        logic       on;
        logic [1:0] src;
        assign on                          = (3'(k) < nb);
        assign src                         = 2'(nb - 3'd1 - 3'(k));
        assign lanes[LAST-k]               = valid && on;
        assign mem_wdata[8*(LAST-k) +: 8]  = (valid && write && on) ? wdata[8*src +: 8] : 8'h00;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_rd
        logic       on;
        logic [1:0] lane;
        logic [7:0] byte_v;
        assign on   = (3'(j) < nb);
        assign lane = 2'(nb - 3'd1 - 3'(j));

        // Select the byte returned on bus byte j.
        always_comb begin : rd_byte_p
            if (!valid || write || !on) begin
                byte_v = 8'h00;
            end else if (io_sel) begin
                byte_v = 8'hFF;
            end else if (mem_sel) begin
                byte_v = mem_rdata[8*(LAST-lane) +: 8];
            end else begin
                byte_v = 8'h00;
            end
        end

        assign bus_rdata[8*j +: 8] = byte_v;
    end

    // R12
    lanes_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (lanes[LAST] && ($countones(lanes) != 3)));
    // R8
    io_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write && io_sel) |-> (bus_rdata == ones_for(size)));

endmodule

// File: rtl/sysdec_regs.sv
// Module: sysdec_regs
// Holds the overlay release flag and the active-low LED register. Both are
// loaded by writes decoded on the effective (overlay-forced) address.
// The flag takes a different data bit for byte writes than for wider ones.
// Synchronous active-low reset: flag cleared, all LEDs off.
module sysdec_regs
    import sysdec_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CTRL_ADDR = 'hE4_3000,
    parameter int LED_ADDR  = 'h4A_0000,
    parameter int LED_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              ctrl_bit_byte,
    input  logic              ctrl_bit_wide,
    input  logic [LED_W-1:0]  led_bits,
    output logic              ram_low_en,
    output logic [LED_W-1:0]  led_n
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] LED_A  = ADDR_W'(LED_ADDR);

    logic ctrl_wr, led_wr;

    assign ctrl_wr = wr_stb && (eff_addr == CTRL_A);
    assign led_wr  = wr_stb && (eff_addr == LED_A) && (size == SZ_WORD);

    // Overlay release flag, bit choice depends on access size.
    always_ff @(posedge clk) begin : ctrl_p
        if (!rst_n) begin
            ram_low_en <= 1'b0;
        end else if (ctrl_wr) begin
            ram_low_en <= (size == SZ_BYTE) ? ctrl_bit_byte : ctrl_bit_wide;
        end
    end

    // LED register, word writes only.
    always_ff @(posedge clk) begin : led_p
        if (!rst_n) begin
            led_n <= '1;
        end else if (led_wr) begin
            led_n <= led_bits;
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (!ram_low_en && (led_n == '1)));
    // R10
    ctrl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (eff_addr == CTRL_A) && (size == SZ_BYTE)) |=> (ram_low_en == $past(ctrl_bit_byte)));
    // R10
    ctrl_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (eff_addr == CTRL_A) && (size != SZ_BYTE)) |=> (ram_low_en == $past(ctrl_bit_wide)));
    // R11
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && (eff_addr == LED_A) && (size == SZ_WORD)) |=> $stable(led_n));

endmodule

// File: rtl/sysbus_decoder.sv
// Module: sysbus_decoder (top)
// System bus address decoder with boot ROM overlay. Combinational decode and
// lane steering for the current access; registered overlay flag and LEDs.
// Assumes one access per cycle qualified by bus_valid, and that the memory
// arrays wrap each byte offset by their own size.
module sysbus_decoder
    import sysdec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int ROM_BYTES  = 'h8000,
    parameter int RAM_BYTES  = 'h8_0000,
    parameter int CTRL_ADDR  = 'hE4_3000,
    parameter int LED_ADDR   = 'h4A_0000,
    parameter int LED_W      = 4,
    parameter int LED_LSB    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_vram,
    output logic              sel_map,
    output logic              sel_io,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [3:0]        mem_lanes,
    output logic              ram_low_en,
    output logic [LED_W-1:0]  led_n
);

    localparam int LANES     = DATA_W / 8;
    localparam int BIT_BYTE  = 7;
    localparam int BIT_WIDE  = 15;

    sel_t              sel;
    logic [ADDR_W-1:0] eff_addr;
    logic              mem_region;
    logic              wr_stb;

    sysdec_region #(
        .ADDR_W    (ADDR_W),
        .ROM_BYTES (ROM_BYTES),
        .RAM_BYTES (RAM_BYTES)
    ) u_region (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (bus_valid),
        .low_en     (ram_low_en),
        .addr       (bus_addr),
        .eff_addr   (eff_addr),
        .local_addr (mem_addr),
        .sel        (sel)
    );

    assign sel_rom    = sel.rom;
    assign sel_ram    = sel.ram;
    assign sel_vram   = sel.vram;
    assign sel_map    = sel.map;
    assign sel_io     = sel.io;
    assign mem_region = sel.rom | sel.ram | sel.vram | sel.map;
    assign wr_stb     = bus_valid && bus_write;

    // Write strobe reaches only the writable arrays; ROM writes are dropped.
    always_comb begin : we_p
        mem_we = wr_stb && (sel.ram || sel.vram || sel.map);
    end

    sysdec_lanes #(
        .LANES (LANES)
    ) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (bus_valid),
        .write     (bus_write),
        .size      (bus_size),
        .mem_sel   (mem_region),
        .io_sel    (sel.io),
        .wdata     (bus_wdata),
        .mem_rdata (mem_rdata),
        .lanes     (mem_lanes),
        .mem_wdata (mem_wdata),
        .bus_rdata (bus_rdata)
    );

    sysdec_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .LED_ADDR  (LED_ADDR),
        .LED_W     (LED_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .size          (bus_size),
        .eff_addr      (eff_addr),
        .ctrl_bit_byte (bus_wdata[BIT_BYTE]),
        .ctrl_bit_wide (bus_wdata[BIT_WIDE]),
        .led_bits      (bus_wdata[LED_LSB +: LED_W]),
        .ram_low_en    (ram_low_en),
        .led_n         (led_n)
    );

    // R9
    rom_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sel_rom) |=> ($stable(ram_low_en) && $stable(led_n)));
    // R9
    rom_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && sel_rom) |-> !mem_we);

endmodule

// File: tb/sim_sysbus_decoder.sv
`timescale 1ns/1ps
module sim_sysbus_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] bus_rdata;
    logic        sel_rom, sel_ram, sel_vram, sel_map, sel_io;
    logic [23:0] mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_lanes;
    logic        ram_low_en;
    logic [3:0]  led_n;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic flag_m = 1'b0;
    logic [3:0] led_m = 4'hF;

    always #2.5 clk = ~clk;

    sysbus_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mem_rdata(mem_rdata), .bus_rdata(bus_rdata), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .sel_vram(sel_vram), .sel_map(sel_map), .sel_io(sel_io),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_lanes(mem_lanes), .ram_low_en(ram_low_en), .led_n(led_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference decode: selects {rom,ram,vram,map,io} and local offset.
    function automatic void ref_decode(input logic [23:0] ea, output logic [4:0] s, output logic [23:0] loc);
        if (ea >= 24'h800000 && ea <= 24'hBFFFFF) begin s = 5'b10000; loc = ea & 24'h007FFF; end
        else if (ea < 24'h080000)                  begin s = 5'b01000; loc = ea; end
        else if (ea >= 24'h420000 && ea <= 24'h427FFF) begin s = 5'b00100; loc = ea & 24'h007FFF; end
        else if (ea >= 24'h400000 && ea <= 24'h4007FF) begin s = 5'b00010; loc = ea & 24'h0007FF; end
        else begin s = 5'b00001; loc = ea; end
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    task automatic access(input logic w, input logic [1:0] sz, input logic [23:0] a,
                          input logic [31:0] d, input logic [31:0] rd, input string req);
        logic [23:0] ea;
        logic [4:0]  es;
        logic [23:0] el;
        logic [31:0] msk;
        logic [31:0] er;
        logic [31:0] ew;
        logic [3:0]  elan;
        int          nb;
        @(negedge clk);
        chk("R10", "overlay flag", {31'b0, ram_low_en}, {31'b0, flag_m});
        chk("R11", "led register", {28'b0, led_n}, {28'b0, led_m});
        bus_valid = 1'b1; bus_write = w; bus_size = sz; bus_addr = a;
        bus_wdata = d; mem_rdata = rd;
        #1;
        ea = flag_m ? a : (a | 24'h800000);
        ref_decode(ea, es, el);
        nb   = nbytes(sz);
        msk  = (nb == 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * nb)) - 32'h1);
        elan = (nb == 1) ? 4'b1000 : (nb == 2) ? 4'b1100 : 4'b1111;
        ew   = w ? ((d & msk) << (32 - 8 * nb)) : 32'h0;
        if (w)          er = 32'h0;
        else if (es[0]) er = msk;
        else            er = rd >> (32 - 8 * nb);
        chk(req, "selects", {27'b0, sel_rom, sel_ram, sel_vram, sel_map, sel_io}, {27'b0, es});
        chk(req, "mem_addr", {8'b0, mem_addr}, {8'b0, el});
        chk("R7", "mem_we", {31'b0, mem_we}, {31'b0, w && (es[3] || es[2] || es[1])});
        chk("R12", "lanes", {28'b0, mem_lanes}, {28'b0, elan});
        chk("R12", "mem_wdata", mem_wdata, ew);
        chk(es[0] ? "R8" : "R12", "bus_rdata", bus_rdata, er);
        if (w && ea == 24'hE43000) flag_m = (sz == 2'b00) ? d[7] : d[15];
        if (w && ea == 24'h4A0000 && sz == 2'b01) led_m = d[11:8];
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1;
        chk("R7", "idle selects", {27'b0, sel_rom, sel_ram, sel_vram, sel_map, sel_io}, 32'h0);
        chk("R7", "idle mem_we", {31'b0, mem_we}, 32'h0);
        @(posedge clk);
    endtask

    initial begin : watchdog
        #(5.0 * 60000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] a;
        logic [1:0]  sz;
        logic        w;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "flag after reset", {31'b0, ram_low_en}, 32'h0);
        chk("R1", "leds after reset", {28'b0, led_n}, 32'hF);
        idle();

        // R2: overlay forces ROM / shifted I/O
        access(1'b0, 2'b10, 24'h000004, 32'h0, 32'h12345678, "R2");
        access(1'b0, 2'b01, 24'h4A0000, 32'h0, 32'h0, "R2");
        access(1'b1, 2'b01, 24'h4A0000, 32'h00000500, 32'h0, "R11");
        access(1'b1, 2'b10, 24'h001234, 32'h0000FFFF, 32'h0, "R9");
        // R10: control bit choice by size
        access(1'b1, 2'b00, 24'hE43000, 32'h00000080, 32'h0, "R10");
        access(1'b1, 2'b01, 24'hE43000, 32'h00000080, 32'h0, "R10");
        access(1'b1, 2'b10, 24'hE43000, 32'h00008000, 32'h0, "R10");
        access(1'b1, 2'b00, 24'hE43000, 32'h00008000, 32'h0, "R10");
        access(1'b1, 2'b11, 24'hE43000, 32'h00008000, 32'h0, "R10");
        // R4..R7 boundaries
        access(1'b0, 2'b00, 24'h07FFFF, 32'h0, 32'hA5000000, "R4");
        access(1'b0, 2'b00, 24'h080000, 32'h0, 32'h0, "R7");
        access(1'b0, 2'b01, 24'h41FFFF, 32'h0, 32'h0, "R5");
        access(1'b0, 2'b01, 24'h420000, 32'h0, 32'hBEEF0000, "R5");
        access(1'b0, 2'b01, 24'h427FFF, 32'h0, 32'h0, "R5");
        access(1'b0, 2'b01, 24'h428000, 32'h0, 32'h0, "R5");
        access(1'b0, 2'b10, 24'h400000, 32'h0, 32'h01020304, "R6");
        access(1'b0, 2'b10, 24'h4007FF, 32'h0, 32'h0, "R6");
        access(1'b0, 2'b10, 24'h400800, 32'h0, 32'h0, "R6");
        access(1'b0, 2'b00, 24'h800000, 32'h0, 32'h77000000, "R3");
        access(1'b0, 2'b00, 24'hBFFFFF, 32'h0, 32'h0, "R3");
        access(1'b0, 2'b00, 24'hC00000, 32'h0, 32'h0, "R8");
        // R9: ROM write ignored
        access(1'b1, 2'b10, 24'h801234, 32'hFFFFFFFF, 32'h0, "R9");
        access(1'b1, 2'b01, 24'hE43000, 32'h00008000, 32'h0, "R10");
        // R11: LEDs
        access(1'b1, 2'b01, 24'h4A0000, 32'h00000A00, 32'h0, "R11");
        access(1'b1, 2'b00, 24'h4A0000, 32'h00000300, 32'h0, "R11");
        access(1'b1, 2'b10, 24'h4A0000, 32'h00000300, 32'h0, "R11");
        // R12: big-endian steering
        access(1'b1, 2'b10, 24'h000100, 32'h11223344, 32'h0, "R12");
        access(1'b1, 2'b01, 24'h000100, 32'h0000AABB, 32'h0, "R12");
        access(1'b1, 2'b00, 24'h000100, 32'h000000CC, 32'h0, "R12");
        access(1'b0, 2'b00, 24'h000100, 32'h0, 32'hDEADBEEF, "R12");
        access(1'b0, 2'b01, 24'h000100, 32'h0, 32'hDEADBEEF, "R12");
        idle();

        // Random mix, biased per region; control writes kept rare.
        for (int i = 0; i < 3000; i++) begin
            int cls;
            cls = int'($urandom % 10);
            sz  = 2'($urandom);
            w   = 1'($urandom);
            case (cls)
                0, 1: a = 24'($urandom % 32'h80000);
                2:    a = 24'h420000 + 24'($urandom % 32'h8000);
                3:    a = 24'h400000 + 24'($urandom % 32'h800);
                4:    a = 24'h800000 + 24'($urandom % 32'h400000);
                5, 6: a = 24'($urandom);
                7:    a = 24'h4A0000;
                8:    a = (($urandom % 4) == 0) ? 24'hE43000 : 24'h3FFFFF;
                default: a = 24'h4007FF + 24'($urandom % 3);
            endcase
            access(w, sz, a, $urandom | 32'h00008080, $urandom, "R7");
            if (($urandom % 16) == 0) idle();
        end
        access(1'b0, 2'b00, 24'h000000, 32'h0, 32'h0, "R7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule